// File: doc/BRIEF.md
# Pipelined Bitonic Sorting Network

This block orders 2^LOG_LANES unsigned words that arrive together on one wide bus. The order is ascending or descending, set by a parameter. It is built by recursion. The left half of the lanes is sorted in the requested direction and the right half in the opposite direction. Together the two sorted halves form a bitonic sequence, and a butterfly merge over all lanes then finishes the order. The compare cell is the only part that sets the direction. The wiring between the cells is the same for both directions.

Each compare-exchange stage is followed by a register stage. Because of this, the block takes one new vector on every clock and returns it LOG_LANES·(LOG_LANES+1)/2 cycles later. A valid flag travels with each vector through the pipeline. A cycle with no input becomes a cycle with no output, and when no vector advances the data registers keep their contents.

The block has no state machine. Its only control is the chain of valid flags, one per stage, which reset clears. If LOG_LANES is 0 there are no stages, and the single lane passes straight through.

Top module: `bitonic_sorter`

## Requirements
- R1: While rst_n is low, and on the first clock after it has been low, out_valid is 0.
- R2: A vector accepted with in_valid high appears with out_valid high exactly LOG_LANES·(LOG_LANES+1)/2 cycles later. The block accepts one vector per cycle back to back, and each idle input cycle appears as an idle output cycle at the same distance.
- R3: With DESCEND=0, the output is in ascending order. Lane k sits at out_data[k*WIDTH +: WIDTH], and lane 0 holds the smallest word. For 8 lanes, the input lanes 0..7 = 8,7,1,2,3,4,6,5 give 1,2,3,4,5,6,7,8.
- R4: With DESCEND=1, lane 0 holds the largest word. The 8-lane input 8,7,1,2,3,4,6,5 gives 8,7,6,5,4,3,2,1.
- R5: Every output vector is a permutation of its input vector, and repeated values keep their multiplicity.
- R6: While out_valid is low after reset, out_data holds the last vector that was delivered with out_valid high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the valid chain |
| in_valid | input | 1 | in_data carries a vector to sort this cycle |
| in_data | input | 2^LOG_LANES·WIDTH | Unsorted lanes, lane k at bits k*WIDTH +: WIDTH |
| out_valid | output | 1 | out_data carries a sorted vector |
| out_data | output | 2^LOG_LANES·WIDTH | Sorted lanes, same packing as in_data |

## Verification
The bench builds three copies of the block.
- 8 lanes of 8 bits, ascending. This copy receives the fixed example vector and random vectors.
- 8 lanes of 8 bits, descending. This copy covers the reversed cells on the same example.
- 16 lanes of 4 bits, descending. With only 16 possible values spread over 16 lanes, most vectors contain duplicates. This copy also has four merge levels, so its latency is 10 stages.

Random gaps in in_valid, plus a long idle burst, exercise the valid alignment and the holding of the output.

// File: rtl/bitonic_pkg.sv
`timescale 1ns/1ps
package bitonic_pkg;

    // Number of compare-exchange stages for 2^log lanes: 1 + 2 + ... + log.
    function automatic int stage_total(input int log_lanes);
        return log_lanes * (log_lanes + 1) / 2;
    endfunction

    // Index of the first stage that belongs to the merge of block size 2^blk.
    function automatic int merge_base(input int blk);
        return blk * (blk - 1) / 2;
    endfunction

endpackage

// File: rtl/bitonic_cell.sv
`timescale 1ns/1ps
// Two-input compare-exchange. lo_out drives the lower lane index.
module bitonic_cell #(
    parameter int W    = 8,
    parameter bit DOWN = 1'b0
) (
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] lo_out,
    output logic [W-1:0] hi_out
);
    logic swap;

    generate
        if (DOWN) begin : g_down
            assign swap = (a_in < b_in);
        end else begin : g_up
            assign swap = (a_in > b_in);
        end
    endgenerate

    assign lo_out = swap ? b_in : a_in;
    assign hi_out = swap ? a_in : b_in;
endmodule

// File: rtl/bitonic_stage.sv
`timescale 1ns/1ps
// One registered butterfly step: lanes whose indices differ in bit DIST
// are compared, within merge blocks of 2^BLK lanes.
module bitonic_stage #(
    parameter int LOG       = 3,
    parameter int W         = 8,
    parameter int BLK       = 1,
    parameter int DIST      = 0,
    parameter bit BASE_DOWN = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [(1<<LOG)*W-1:0] in_data,
    output logic                  out_valid,
    output logic [(1<<LOG)*W-1:0] out_data
);
    localparam int LANES = 1 << LOG;
    localparam int BUSW  = LANES * W;
    localparam int SUMW  = W + LOG;

    logic [BUSW-1:0] mix;

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            if (((i >> DIST) & 1) == 0) begin : g_pair
                localparam int J  = i + (1 << DIST);
                // Sub-sorter direction flips once per set bit above the block.
                localparam bit DN = BASE_DOWN ^ (^(i >> BLK));
                bitonic_cell #(.W(W), .DOWN(DN)) u_cell (
                    .a_in  (in_data[i*W +: W]),
                    .b_in  (in_data[J*W +: W]),
                    .lo_out(mix[i*W +: W]),
                    .hi_out(mix[J*W +: W])
                );
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    always_ff @(posedge clk) begin
        if (in_valid) out_data <= mix;
    end

    function automatic logic [SUMW-1:0] lane_sum(input logic [BUSW-1:0] v);
        logic [SUMW-1:0] s;
        s = '0;
        for (int k = 0; k < LANES; k++) s = s + SUMW'(v[k*W +: W]);
        return s;
    endfunction

    // R2: valid flag advances exactly one stage per clock
    assert_valid_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_bubble_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R5: exchange loses no value
    assert_sum_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (lane_sum(out_data) == $past(lane_sum(in_data))));
    // R6: data register frozen on a bubble
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));
endmodule

// File: rtl/bitonic_sorter.sv
`timescale 1ns/1ps
module bitonic_sorter #(
    parameter int LOG_LANES = 3,
    parameter int WIDTH     = 8,
    parameter bit DESCEND   = 1'b0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [(1<<LOG_LANES)*WIDTH-1:0] in_data,
    output logic                        out_valid,
    output logic [(1<<LOG_LANES)*WIDTH-1:0] out_data
);
    import bitonic_pkg::*;

    localparam int LANES  = 1 << LOG_LANES;
    localparam int BUSW   = LANES * WIDTH;
    localparam int NSTAGE = stage_total(LOG_LANES);

    logic            pipe_valid [NSTAGE+1];
    logic [BUSW-1:0] pipe_data  [NSTAGE+1];

    assign pipe_valid[0] = in_valid;
    assign pipe_data[0]  = in_data;

    // Merge of size 2^p follows the sorted halves of size 2^(p-1);
    // inside it the compare distance halves from 2^(p-1) down to 1.
    generate
        for (genvar p = 1; p <= LOG_LANES; p++) begin : g_merge
            for (genvar k = 0; k < p; k++) begin : g_step
                localparam int IDX = merge_base(p) + k;
                bitonic_stage #(
                    .LOG      (LOG_LANES),
                    .W        (WIDTH),
                    .BLK      (p),
                    .DIST     (p - 1 - k),
                    .BASE_DOWN(DESCEND)
                ) u_stage (
                    .clk      (clk),
                    .rst_n    (rst_n),
                    .in_valid (pipe_valid[IDX]),
                    .in_data  (pipe_data[IDX]),
                    .out_valid(pipe_valid[IDX+1]),
                    .out_data (pipe_data[IDX+1])
                );
            end
        end
    endgenerate

    assign out_valid = pipe_valid[NSTAGE];
    assign out_data  = pipe_data[NSTAGE];

    function automatic logic in_order(input logic [BUSW-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int k = 0; k + 1 < LANES; k++) begin
            if (DESCEND ? (v[k*WIDTH +: WIDTH] < v[(k+1)*WIDTH +: WIDTH])
                        : (v[k*WIDTH +: WIDTH] > v[(k+1)*WIDTH +: WIDTH]))
                ok = 1'b0;
        end
        return ok;
    endfunction

    // R3 (ascending) and R4 (descending): every delivered vector is ordered
    assert_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> in_order(out_data));

    generate
        if (NSTAGE > 0) begin : g_rst_chk
            assert_reset_quiet_R1: assert property (@(posedge clk)
                !rst_n |=> !out_valid);
        end
    endgenerate
endmodule

// File: tb/bitonic_sorter_tb_top.sv
`timescale 1ns/1ps
// Stimulus and behavioural reference for one configuration.
module sorter_env #(
    parameter int LOG  = 3,
    parameter int W    = 8,
    parameter bit DOWN = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    output int   checks,
    output int   errors,
    output logic done
);
    localparam int LANES = 1 << LOG;
    localparam int BUSW  = LANES * W;
    localparam int LAT   = LOG * (LOG + 1) / 2;
    localparam int NVEC  = 400;

    logic            in_valid;
    logic [BUSW-1:0] in_data;
    logic            out_valid;
    logic [BUSW-1:0] out_data;

    bitonic_sorter #(.LOG_LANES(LOG), .WIDTH(W), .DESCEND(DOWN)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    bit            vq [$];
    logic [BUSW-1:0] dq [$];

    function automatic logic [BUSW-1:0] ref_sort(input logic [BUSW-1:0] v, input bit down);
        int a [LANES];
        int t;
        logic [BUSW-1:0] r;
        for (int k = 0; k < LANES; k++) a[k] = int'(v[k*W +: W]);
        for (int x = 0; x < LANES; x++)
            for (int y = 0; y + 1 < LANES - x; y++)
                if (down ? (a[y] < a[y+1]) : (a[y] > a[y+1])) begin
                    t = a[y]; a[y] = a[y+1]; a[y+1] = t;
                end
        for (int k = 0; k < LANES; k++) r[k*W +: W] = W'(a[k]);
        return r;
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [BUSW-1:0] act, input logic [BUSW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s lanes=%0d: actual %h expected %h", req, LANES, act, exp);
        end
    endtask

    initial begin
        bit              ev;
        logic [BUSW-1:0] ed;
        logic [BUSW-1:0] last;
        bit              have_last;
        int              n;
        int              stated [8];
        stated = '{8, 7, 1, 2, 3, 4, 6, 5};
        checks = 0; errors = 0; done = 1'b0;
        in_valid = 1'b0; in_data = '0;
        have_last = 1'b0; last = '0; n = 0;
        for (int k = 0; k < LAT; k++) begin vq.push_back(1'b0); dq.push_back('0); end
        while (n < NVEC + LAT + 4) begin
            @(negedge clk);
            if (!rst_n) begin
                chk(out_valid == 1'b0, "R1", BUSW'(out_valid), '0);
                continue;
            end
            ev = vq.pop_front();
            ed = dq.pop_front();
            chk(out_valid == ev, "R2", BUSW'(out_valid), BUSW'(ev));
            if (ev) begin
                // R3/R4: ordered output, including the stated example vector
                chk(out_data == ed, DOWN ? "R4" : "R3", out_data, ed);
                chk(ref_sort(out_data, 1'b0) == ref_sort(ed, 1'b0), "R5",
                    ref_sort(out_data, 1'b0), ref_sort(ed, 1'b0));
                last = ed; have_last = 1'b1;
            end else if (have_last) begin
                chk(out_data == last, "R6", out_data, last);
            end
            // next input
            in_valid = 1'b0;
            if (n < NVEC) begin
                if (n == 0) begin
                    in_valid = 1'b1;
                    for (int k = 0; k < LANES; k++) in_data[k*W +: W] = W'(stated[k % 8]);
                end else if (n == 1) begin
                    in_valid = 1'b1;
                    for (int k = 0; k < LANES; k++) in_data[k*W +: W] = W'(3);
                end else if (n == 2 || n == 3) begin
                    in_valid = 1'b1;
                    for (int k = 0; k < LANES; k++)
                        in_data[k*W +: W] = W'((n == 2) ? k : LANES - 1 - k);
                end else if (n >= 200 && n < 240) begin
                    in_valid = 1'b0;
                    in_data = '1;
                end else begin
                    in_valid = (n < 40) || ($urandom_range(0, 3) != 0);
                    for (int k = 0; k < LANES; k++)
                        in_data[k*W +: W] = W'($urandom_range(0, (1 << W) - 1));
                end
            end
            vq.push_back(in_valid);
            dq.push_back(ref_sort(in_data, DOWN));
            n++;
        end
        done = 1'b1;
    end
endmodule

module bitonic_sorter_tb_top;
    logic clk = 1'b0;
    logic rst_n;
    int   c0, c1, c2, e0, e1, e2;
    logic d0, d1, d2;
    int   wd_err;

    always #10 clk = ~clk;

    initial begin
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    end

    sorter_env #(.LOG(3), .W(8), .DOWN(1'b0)) env_asc8   (.clk(clk), .rst_n(rst_n), .checks(c0), .errors(e0), .done(d0));
    sorter_env #(.LOG(3), .W(8), .DOWN(1'b1)) env_desc8  (.clk(clk), .rst_n(rst_n), .checks(c1), .errors(e1), .done(d1));
    sorter_env #(.LOG(4), .W(4), .DOWN(1'b1)) env_desc16 (.clk(clk), .rst_n(rst_n), .checks(c2), .errors(e2), .done(d2));

    initial begin
        int cyc;
        cyc = 0; wd_err = 0;
        while (!(d0 === 1'b1 && d1 === 1'b1 && d2 === 1'b1) && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (cyc >= 20000) begin
            wd_err = 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        end
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors",
                 c0 + c1 + c2 + 1, e0 + e1 + e2 + wd_err);
        $finish;
    end
endmodule